// File: doc/BRIEF.md
# Masked Logo Overlay Blender

This block places a logo over a video stream. Each beat carries a group of pixels from the video, the matching pixels of the logo and one 8-bit weight per pixel. For every pixel, and separately for each of its three colour planes (luma and the two chroma planes), the block forms a weighted mix. The video sample is weighted by the complement of the mask and the logo sample by the mask itself. The 16-bit sum is then scaled back to 8 bits by dividing it by 255 and rounding to the nearest value.

Video, logo and mask arrive together in one wide beat under a single valid/ready handshake, and the blended pixels leave through a second valid/ready handshake. The default width is 20 pixels per beat, which is 480 bits of pixel data. That fits a 512-bit memory-side word. At one beat per clock, a modest clock carries 1080p video at 30 frames per second many times over. The datapath has three register stages. It stalls as a whole when the consumer holds off, and no beat is lost.

Top module: `logo_overlay_blend`

## Requirements
- R1: For each pixel and plane, the output equals round(((255 − m)·v + m·l) / 255), rounded to the nearest integer. Here v is the video sample, l is the logo sample and m is the pixel's mask.
- R2: A mask value of 255 gives exactly the logo sample on all three planes.
- R3: A mask value of 0 gives exactly the video sample on all three planes.
- R4: Pixel p of a beat occupies bits [24p+23:24p] of the video, logo and output buses. Within a pixel, luma is bits [7:0], blue chroma is bits [15:8] and red chroma is bits [23:16]. The mask of pixel p is bits [8p+7:8p] of the mask bus. All three planes of a pixel use that one mask, and pixels do not affect one another.
- R5: Suppose a beat is accepted at a rising edge and out_ready is high at the next two edges. The beat is then on the output with out_valid high right after the second of those edges.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_pixels holds its value.
- R7: Beats leave in the order they were accepted, with none dropped and none duplicated. At most three beats are held. With out_ready low and three beats held, in_ready is low.
- R8: While reset is asserted, out_valid is low and in_ready is high.
- R9: While out_ready stays high, in_ready stays high, so one beat is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The block accepts the offered beat at this edge |
| in_video | input | 480 | Video pixels, 24 bits each |
| in_logo | input | 480 | Logo pixels aligned with the video pixels |
| in_mask | input | 160 | One 8-bit logo weight per pixel |
| out_valid | output | 1 | A blended beat is presented |
| out_ready | input | 1 | The consumer takes the presented beat |
| out_pixels | output | 480 | Blended pixels, same layout as in_video |

## Verification
The hardest case to reach from the ports is a full pipeline stalled at the output while the producer keeps offering beats, followed by irregular releases. In that case each stage must decide, edge by edge, whether to move, hold or take a new beat. The stimulus holds out_ready low until in_ready falls and checks that exactly three beats were taken. It then drives a stream with gaps on the input against a repeating out_ready pattern, so that moves and holds interleave in every stage. Each output beat is compared with a model of the weighted mix, in the order the beats were accepted.

// File: rtl/lob_pkg.sv
package lob_pkg;
  localparam int COMP_W     = 8;
  localparam int NUM_PLANES = 3;
  localparam int PIPE_DEPTH = 3;
  localparam int SUM_W      = 2 * COMP_W;
  localparam int PIX_W      = NUM_PLANES * COMP_W;

  typedef logic [COMP_W-1:0] comp_t;
  typedef logic [SUM_W-1:0]  sum_t;

  localparam comp_t FULL_WEIGHT = '1;
  localparam sum_t  ROUND_BIAS  = sum_t'(1) << (COMP_W - 1);
endpackage

// File: rtl/lob_stage_ctrl.sv
module lob_stage_ctrl #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [DEPTH-1:0] load
);
  logic [DEPTH-1:0] full_q;
  logic [DEPTH-1:0] full_d;
  logic [DEPTH-1:0] open;
  logic [DEPTH-1:0] feed;

  // A stage may take new contents when it is empty or its successor moves.
  always_comb begin
    open[DEPTH-1] = ~full_q[DEPTH-1] | dn_ready;
    for (int i = DEPTH - 2; i >= 0; i--) begin
      open[i] = ~full_q[i] | open[i+1];
    end
  end

  // Occupancy flowing into each stage.
  always_comb begin
    feed[0] = up_valid;
    for (int i = 1; i < DEPTH; i++) begin
      feed[i] = full_q[i-1];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      full_d[i] = open[i] ? feed[i] : full_q[i];
      load[i]   = open[i] & feed[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  assign up_ready = open[0];
  assign dn_valid = full_q[DEPTH-1];
endmodule

// File: rtl/lob_weigh.sv
module lob_weigh
  import lob_pkg::*;
(
  input  comp_t src,
  input  comp_t logo,
  input  comp_t mask,
  output sum_t  sum
);
  comp_t keep;

  always_comb begin
    keep = FULL_WEIGHT - mask;
    sum  = sum_t'(keep) * sum_t'(src) + sum_t'(mask) * sum_t'(logo);
  end
endmodule

// File: rtl/lob_norm255.sv
module lob_norm255
  import lob_pkg::*;
(
  input  sum_t  biased,
  output comp_t value
);
  // biased already holds sum + half; adding its upper byte and keeping the
  // upper byte divides by 255 exactly over the range a weighted sum reaches.
  always_comb begin
    value = comp_t'((biased + (biased >> COMP_W)) >> COMP_W);
  end
endmodule

// File: rtl/lob_lane.sv
module lob_lane
  import lob_pkg::*;
(
  input  logic                  clk,
  input  logic [PIPE_DEPTH-1:0] load,
  input  logic [PIX_W-1:0]      src_pix,
  input  logic [PIX_W-1:0]      logo_pix,
  input  comp_t                 mask,
  output logic [PIX_W-1:0]      res_pix
);
  for (genvar c = 0; c < NUM_PLANES; c++) begin : g_plane
    sum_t  wsum_d, wsum_q;
    sum_t  bias_d, bias_q;
    comp_t norm_d, norm_q;

    lob_weigh u_weigh (
      .src  (src_pix[c*COMP_W +: COMP_W]),
      .logo (logo_pix[c*COMP_W +: COMP_W]),
      .mask (mask),
      .sum  (wsum_d)
    );

    always_comb begin
      bias_d = wsum_q + ROUND_BIAS;
    end

    lob_norm255 u_norm (
      .biased (bias_q),
      .value  (norm_d)
    );

    always_ff @(posedge clk) begin
      if (load[0]) wsum_q <= wsum_d;
      if (load[1]) bias_q <= bias_d;
      if (load[2]) norm_q <= norm_d;
    end

    assign res_pix[c*COMP_W +: COMP_W] = norm_q;
  end
endmodule

// File: rtl/logo_overlay_blend.sv
module logo_overlay_blend
  import lob_pkg::*;
#(
  parameter int PIX_PER_BEAT = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [PIX_PER_BEAT*PIX_W-1:0]    in_video,
  input  logic [PIX_PER_BEAT*PIX_W-1:0]    in_logo,
  input  logic [PIX_PER_BEAT*COMP_W-1:0]   in_mask,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [PIX_PER_BEAT*PIX_W-1:0]    out_pixels
);
  logic [PIPE_DEPTH-1:0] load;

  lob_stage_ctrl #(.DEPTH(PIPE_DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .load     (load)
  );

  for (genvar p = 0; p < PIX_PER_BEAT; p++) begin : g_pix
    lob_lane u_lane (
      .clk      (clk),
      .load     (load),
      .src_pix  (in_video[p*PIX_W +: PIX_W]),
      .logo_pix (in_logo[p*PIX_W +: PIX_W]),
      .mask     (in_mask[p*COMP_W +: COMP_W]),
      .res_pix  (out_pixels[p*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/lob_checker.sv
module lob_checker #(
  parameter int PIX_PER_BEAT = 20
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [PIX_PER_BEAT*24-1:0] in_video,
  input logic [PIX_PER_BEAT*24-1:0] in_logo,
  input logic [PIX_PER_BEAT*8-1:0]  in_mask,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [PIX_PER_BEAT*24-1:0] out_pixels
);
  localparam int BW = PIX_PER_BEAT * 24;
  localparam int MW = PIX_PER_BEAT * 8;

  function automatic logic [BW-1:0] ref_beat(input logic [BW-1:0] v,
                                             input logic [BW-1:0] l,
                                             input logic [MW-1:0] m);
    logic [BW-1:0] r;
    int s;
    for (int p = 0; p < PIX_PER_BEAT; p++) begin
      for (int c = 0; c < 3; c++) begin
        s = (255 - int'(m[p*8 +: 8])) * int'(v[p*24+c*8 +: 8])
            + int'(m[p*8 +: 8]) * int'(l[p*24+c*8 +: 8]);
        r[p*24+c*8 +: 8] = 8'((s + 127) / 255);
      end
    end
    return r;
  endfunction

  logic fire_in, fire_out;
  logic [2:0] occ;
  assign fire_in  = in_valid & in_ready;
  assign fire_out = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + {2'b0, fire_in} - {2'b0, fire_out};
  end

  // R5: three-stage latency with the consumer ready
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire_in, 3) && $past(out_ready, 2) && $past(out_ready, 1)) |-> out_valid);

  // R1: arithmetic of the beat that left through the pipe
  a_r1_mix: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire_in, 3) && $past(out_ready, 2) && $past(out_ready, 1)) |->
      (out_pixels == ref_beat($past(in_video, 3), $past(in_logo, 3), $past(in_mask, 3))));

  // R6: output held under backpressure
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixels)));

  // R7: bounded occupancy
  a_r7_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd3);

  // R7: nothing presented that was not accepted
  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ != 3'd0));

  // R7: full and stalled refuses input
  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 3'd3 && !out_ready) |-> !in_ready);
endmodule

bind logo_overlay_blend lob_checker #(.PIX_PER_BEAT(PIX_PER_BEAT)) u_lob_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_video   (in_video),
  .in_logo    (in_logo),
  .in_mask    (in_mask),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pixels (out_pixels)
);

// File: tb/tb_logo_overlay_blend.sv
module tb_logo_overlay_blend;
  localparam int PIX = 20;
  localparam int BW  = PIX * 24;
  localparam int MW  = PIX * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [BW-1:0] in_video;
  logic [BW-1:0] in_logo;
  logic [MW-1:0] in_mask;
  logic          out_valid;
  logic          out_ready;
  logic [BW-1:0] out_pixels;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  logic [BW-1:0] exp_q [0:255];
  int    wr_idx = 0;
  int    rd_idx = 0;

  always #2 clk = ~clk;

  logo_overlay_blend #(.PIX_PER_BEAT(PIX)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_video(in_video), .in_logo(in_logo), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixels(out_pixels)
  );

  function automatic logic [BW-1:0] model(input logic [BW-1:0] v,
                                          input logic [BW-1:0] l,
                                          input logic [MW-1:0] m);
    logic [BW-1:0] r;
    int s, mm;
    for (int p = 0; p < PIX; p++) begin
      mm = int'(m[p*8 +: 8]);
      for (int c = 0; c < 3; c++) begin
        s = (255 - mm) * int'(v[p*24+c*8 +: 8]) + mm * int'(l[p*24+c*8 +: 8]);
        r[p*24+c*8 +: 8] = 8'((2 * s + 255) / 510);
      end
    end
    return r;
  endfunction

  // Scoreboard: sampled at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (in_valid && in_ready) begin
        exp_q[wr_idx % 256] = model(in_video, in_logo, in_mask);
        wr_idx++;
      end
      if (out_valid && out_ready) begin
        checks++;
        if (rd_idx >= wr_idx) begin
          errors++;
          $display("FAIL R7 extra beat %0d got %h exp none", rd_idx, out_pixels);
        end else if (out_pixels !== exp_q[rd_idx % 256]) begin
          errors++;
          $display("FAIL %s beat %0d got %h exp %h", tag, rd_idx, out_pixels,
                   exp_q[rd_idx % 256]);
        end
        rd_idx++;
      end
    end
  end

  task automatic make_beat(input int mode, output logic [BW-1:0] v,
                           output logic [BW-1:0] l, output logic [MW-1:0] m);
    for (int p = 0; p < PIX; p++) begin
      for (int c = 0; c < 3; c++) begin
        v[p*24+c*8 +: 8] = 8'($urandom);
        l[p*24+c*8 +: 8] = 8'($urandom);
      end
      case (mode)
        1:       m[p*8 +: 8] = 8'd0;
        2:       m[p*8 +: 8] = 8'd255;
        3:       m[p*8 +: 8] = (p % 2 == 0) ? 8'd0 : 8'd255;
        default: m[p*8 +: 8] = 8'($urandom);
      endcase
    end
  endtask

  task automatic send(input int mode);
    logic [BW-1:0] v, l;
    logic [MW-1:0] m;
    make_beat(mode, v, l, m);
    in_video = v; in_logo = l; in_mask = m; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain(input string rq);
    int t = 0;
    while (rd_idx != wr_idx && t < 300) begin
      @(negedge clk);
      t++;
    end
    checks++;
    if (rd_idx != wr_idx) begin
      errors++;
      $display("FAIL %s drained got %0d exp %0d", rq, rd_idx, wr_idx);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
        errors++;
        $display("FAIL R8 got valid=%b ready=%b exp valid=0 ready=1", out_valid, in_ready);
      end
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_extremes();
    out_ready = 1'b1;
    tag = "R2"; send(2); send(2); drain("R2");
    tag = "R3"; send(1); send(1); drain("R3");
    tag = "R4"; send(3); send(3); drain("R4");
  endtask

  task automatic t_mix();
    out_ready = 1'b1;
    tag = "R1";
    for (int k = 0; k < 12; k++) send(0);
    drain("R1");
  endtask

  task automatic t_latency();
    int n;
    logic [BW-1:0] v, l;
    logic [MW-1:0] m;
    out_ready = 1'b1;
    tag = "R5";
    make_beat(0, v, l, m);
    in_video = v; in_logo = l; in_mask = m; in_valid = 1'b1;
    @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 10);
    checks++;
    if (n != 3) begin
      errors++;
      $display("FAIL R5 latency got %0d exp 3", n);
    end
    drain("R5");
  endtask

  task automatic t_backpressure();
    int taken = 0;
    logic [BW-1:0] v, l, snap;
    logic [MW-1:0] m;
    logic bad = 1'b0;
    out_ready = 1'b0;
    tag = "R7";
    for (int k = 0; k < 6; k++) begin
      make_beat(0, v, l, m);
      in_video = v; in_logo = l; in_mask = m; in_valid = 1'b1;
      @(negedge clk);
      if (in_ready) taken++;
      @(posedge clk); #1;
    end
    @(negedge clk);
    checks++;
    if (taken != 3 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R7 held got %0d ready=%b exp 3 ready=0", taken, in_ready);
    end
    in_valid = 1'b0;
    snap = out_pixels;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (out_valid !== 1'b1 || out_pixels !== snap) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R6 hold got %h exp %h", out_pixels, snap);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    drain("R7");
  endtask

  task automatic t_stream();
    bit done = 0;
    tag = "R7";
    fork
      begin
        for (int k = 0; k < 30; k++) begin
          send(0);
          if (k % 4 == 3) begin @(posedge clk); #1; end
        end
        done = 1;
      end
      begin
        int c = 0;
        while (!done) begin
          @(posedge clk); #1;
          out_ready = (c % 5 != 1) && (c % 7 != 3);
          c++;
        end
      end
    join
    out_ready = 1'b1;
    drain("R7");
  endtask

  task automatic t_throughput();
    logic [BW-1:0] v, l;
    logic [MW-1:0] m;
    int stalls = 0;
    out_ready = 1'b1;
    tag = "R9";
    for (int k = 0; k < 10; k++) begin
      make_beat(0, v, l, m);
      in_video = v; in_logo = l; in_mask = m; in_valid = 1'b1;
      @(negedge clk);
      if (!in_ready) stalls++;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    checks++;
    if (stalls != 0) begin
      errors++;
      $display("FAIL R9 stalls got %0d exp 0", stalls);
    end
    drain("R9");
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_video = '0;
    in_logo = '0;
    in_mask = '0;
    t_reset();
    t_extremes();
    t_mix();
    t_latency();
    t_backpressure();
    t_stream();
    t_throughput();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule